// File: doc/BRIEF.md
# Barrel Thread Picker

This block is the per-cycle thread-selection stage of an in-order, fine-grained multithreaded core. It serves eight hardware threads that sit in two fixed groups of four. Each group feeds its own integer unit. Every cycle the block looks at each thread's instruction-valid flag, the decoded class of that instruction and the thread's blocking state. It then grants at most one thread in each group. The two grants are made in the same cycle, and one group's choice does not change the other's, except where both would start a divide.

Grants are combinational from the current inputs and state. A thread that holds a grant during a cycle issues at the next rising clock edge, and its blocking state changes at that edge. A multiply blocks only the thread that issued it. The divider is a single unpipelined unit shared by all eight threads. A floating-point operation that depends on an earlier floating-point result of the same thread waits a fixed number of cycles after that earlier operation issued. A parameter chooses how multiplies and divides complete: either an internal countdown of the configured latency or an external done pulse per thread. The default is the internal countdown.

Top module: `barrel_picker`

## Requirements
- R1: After a synchronous reset with no valid instructions, `grant` is zero and `grp_valid` is zero. Each group's search starts at its lowest-numbered thread, so with all threads requesting, the first grants go to threads 0 and 4.
- R2: In each group (group g owns threads 4g to 4g+3), at most one grant bit is set, and only for a thread whose instruction is valid. `grp_valid[g]` is high exactly when that group grants. `grp_tid` slice g (3 bits at [3g+2:3g]) gives the global number of the granted thread.
- R3: Within a group, the search starts at the thread after the one granted last and wraps around. Threads that are not ready are skipped. With all four threads requesting, the grants rotate 0,1,2,3,0.
- R4: When no thread in a group is ready, that group's grant bits are zero and its `grp_valid` bit is low.
- R5: The instruction class of thread t is `op_class[2t+1:2t]`: 0 is a simple ALU operation, 1 an integer multiply, 2 an integer divide and 3 a floating-point operation.
- R6: A multiply issued by a thread keeps that thread from being granted for the next MUL_LAT cycles (default 5). Other threads are unaffected and may issue multiplies on consecutive cycles.
- R7: Only one divide is in flight across all threads. The issuing thread is not granted for the next DIV_LAT cycles (default 24). During that time no other thread's divide is granted, while ALU operations of other threads still issue.
- R8: If both groups would grant a divide in the same cycle while the divider is free, group 0's divide wins. Group 1 then grants another ready thread, or nothing.
- R9: A floating-point operation with its `fp_dep` bit set is not granted until FP_LAT cycles (default 6) after that thread's previous floating-point issue. A floating-point operation with `fp_dep` clear does not wait.
- R10: With the default internal completion, pulses on `mul_done` and `div_done` have no effect on grants.
- R11: A group keeps granting while the other group is idle or blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_valid | input | 8 | Per-thread flag: an instruction is waiting |
| op_class | input | 16 | Per-thread 2-bit instruction class |
| fp_dep | input | 8 | Per-thread flag: FP operation depends on a prior FP result |
| mul_done | input | 8 | Per-thread multiply completion pulse (external mode only) |
| div_done | input | 8 | Per-thread divide completion pulse (external mode only) |
| grant | output | 8 | One-hot-per-group issue grant |
| grp_valid | output | 2 | Group has a grant this cycle |
| grp_tid | output | 6 | Global thread number granted, 3 bits per group |

## Verification
The bench targets the cycle a blocked thread becomes eligible again, for multiply, divide and floating-point dependency. A countdown that is off by one grants one cycle early or one cycle late at that boundary. Rotation is checked with dense and sparse request sets. A pointer that does not advance past the granted thread keeps granting the same thread, and one that does not wrap skips threads. Two divides are made to collide in the same cycle, and a divide is requested while the divider is busy. A missing cross-group mask would start two divides. Done pulses sent during a divide in the default mode would, if not ignored, release the owner early.

// File: rtl/bp_pkg.sv
// Shared types for the barrel thread picker.
// Assumes a 2-bit instruction class field per thread.
package bp_pkg;

    typedef enum logic [1:0] {
        OP_ALU = 2'd0,
        OP_MUL = 2'd1,
        OP_DIV = 2'd2,
        OP_FP  = 2'd3
    } op_e;

endpackage

// File: rtl/bp_thread_state.sv
// Per-thread blocking state: outstanding multiply and the floating-point
// dependency countdown. Produces readiness without the shared-divider terms.
// Assumes MUL_LAT >= 1 and FP_LAT >= 1, and that issue is only raised when
// ready_nd was high in the same cycle.
module bp_thread_state
    import bp_pkg::*;
#(
    parameter int MUL_LAT  = 5,
    parameter int FP_LAT   = 6,
    parameter bit EXT_DONE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inst_valid,
    input  op_e  op,
    input  logic fp_dep,
    input  logic issue,
    input  logic mul_done,
    output logic ready_nd
);

    localparam int FW = $clog2(FP_LAT + 1);
    localparam int MW = $clog2(MUL_LAT + 1);

    logic          mul_blk;
    logic [FW-1:0] fp_cnt_q;
    logic          fp_wait;

    generate
        if (EXT_DONE) begin : g_ext
            logic busy_q;
            // Mark the multiply busy on issue, release on the done pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)                   busy_q <= 1'b0;
                else if (issue && op == OP_MUL) busy_q <= 1'b1;
                else if (mul_done)            busy_q <= 1'b0;
            end
            assign mul_blk = busy_q;
        end else begin : g_cnt
            logic [MW-1:0] cnt_q;
            logic          unused_done;
            assign unused_done = mul_done;
            // Count down the fixed multiply latency after issue.
            always_ff @(posedge clk) begin
                if (!rst_n)                   cnt_q <= '0;
                else if (issue && op == OP_MUL) cnt_q <= MW'(MUL_LAT);
                else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
            end
            assign mul_blk = (cnt_q != '0);
        end
    endgenerate

    // Restart the FP spacing window whenever this thread issues an FP op.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fp_cnt_q <= '0;
        else if (issue && op == OP_FP) fp_cnt_q <= FW'(FP_LAT - 1);
        else if (fp_cnt_q != '0)       fp_cnt_q <= fp_cnt_q - 1'b1;
    end

    // A dependent FP op must wait for the window to close.
    always_comb fp_wait = (op == OP_FP) && fp_dep && (fp_cnt_q != '0);

    // Readiness apart from the shared divider.
    always_comb ready_nd = inst_valid && !mul_blk && !fp_wait;

    // R6: a multiply issue blocks the thread on the following cycle.
    a_r6_mul_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_MUL) |=> !ready_nd);

    // R9: a dependent FP op never issues inside the spacing window.
    a_r9_fp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_FP && fp_dep) |-> (fp_cnt_q == '0));

endmodule

// File: rtl/bp_div_track.sv
// Tracks the single shared, unpipelined divider: which thread owns it and
// when it frees up. Assumes at most one divide issue per cycle and DIV_LAT >= 1.
module bp_div_track #(
    parameter int NT       = 8,
    parameter int DIV_LAT  = 24,
    parameter bit EXT_DONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] issue_vec,
    input  logic [NT-1:0] div_done,
    output logic          div_free,
    output logic [NT-1:0] div_owner
);

    localparam int DW = $clog2(DIV_LAT + 1);

    logic [NT-1:0] owner_q;

    generate
        if (EXT_DONE) begin : g_ext
            // Capture the owner on issue, release on its done pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)                    owner_q <= '0;
                else if (|issue_vec)           owner_q <= issue_vec;
                else if (|(div_done & owner_q)) owner_q <= '0;
            end
        end else begin : g_cnt
            logic [DW-1:0] cnt_q;
            logic          unused_done;
            assign unused_done = ^div_done;
            // Capture the owner and run the fixed divide latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q   <= '0;
                    owner_q <= '0;
                end else if (|issue_vec) begin
                    cnt_q   <= DW'(DIV_LAT);
                    owner_q <= issue_vec;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == DW'(1)) owner_q <= '0;
                end
            end
        end
    endgenerate

    assign div_owner = owner_q;
    assign div_free  = (owner_q == '0);

    // R7: only one divide starts at a time.
    a_r7_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vec));

    // R7: a divide only starts on a free divider.
    a_r7_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (|issue_vec) |-> div_free);

    // R7: the issuing thread owns the divider on the next cycle.
    a_r7_owner_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (|issue_vec) |=> (div_owner == $past(issue_vec)));

endmodule

// File: rtl/bp_group_arb.sv
// Rotating-priority arbiter for one thread group. The thread after the last
// granted one has top priority; reset points at thread 0.
// Assumes N >= 2.
module bp_group_arb #(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          valid,
    output logic [$clog2(N)-1:0] idx
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_q;

    // Search from the pointer, wrapping, for the first requester.
    always_comb begin
        gnt   = '0;
        valid = 1'b0;
        idx   = '0;
        for (int off = 0; off < N; off++) begin
            int pos;
            pos = (int'(ptr_q) + off) % N;
            if (!valid && req[pos]) begin
                valid    = 1'b1;
                idx      = IW'(pos);
                gnt[pos] = 1'b1;
            end
        end
    end

    // Move top priority just past the granted thread.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (valid) ptr_q <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
    end

    // R2: never more than one grant in the group.
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R2: grants only go to requesters.
    a_r2_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R4: no requester, no valid.
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !valid);

    // R3: a thread granted alone with others waiting is not granted next.
    a_r3_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $countones(req) > 1) |=> !(valid && req == $past(req) && gnt == $past(gnt)));

endmodule

// File: rtl/barrel_picker.sv
// Barrel thread picker: two (NUM_GROUPS) independent per-cycle picks over
// fixed thread groups, with per-thread multiply and FP-dependency blocking
// and one shared divider. Grants are combinational; issue happens at the
// clock edge that ends a granted cycle. Lower-numbered groups win a divide
// race.
module barrel_picker
    import bp_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_SIZE = 4,
    parameter int MUL_LAT    = 5,
    parameter int DIV_LAT    = 24,
    parameter int FP_LAT     = 6,
    parameter bit EXT_DONE   = 1'b0,
    localparam int NT        = NUM_GROUPS * GROUP_SIZE,
    localparam int TIDW      = $clog2(NT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NT-1:0]              inst_valid,
    input  logic [2*NT-1:0]            op_class,
    input  logic [NT-1:0]              fp_dep,
    input  logic [NT-1:0]              mul_done,
    input  logic [NT-1:0]              div_done,
    output logic [NT-1:0]              grant,
    output logic [NUM_GROUPS-1:0]      grp_valid,
    output logic [NUM_GROUPS*TIDW-1:0] grp_tid
);

    localparam int GIW = $clog2(GROUP_SIZE);

    op_e           ops [NT];
    logic [NT-1:0] ready_nd;
    logic [NT-1:0] is_div;
    logic          div_free;
    logic [NT-1:0] div_owner;

    genvar t, g;

    generate
        for (t = 0; t < NT; t++) begin : g_thr
            // Decode this thread's class field.
            always_comb begin
                ops[t]    = op_e'(op_class[2*t +: 2]);
                is_div[t] = (op_class[2*t +: 2] == OP_DIV);
            end

            bp_thread_state #(
                .MUL_LAT (MUL_LAT),
                .FP_LAT  (FP_LAT),
                .EXT_DONE(EXT_DONE)
            ) u_state (
                .clk       (clk),
                .rst_n     (rst_n),
                .inst_valid(inst_valid[t]),
                .op        (ops[t]),
                .fp_dep    (fp_dep[t]),
                .issue     (grant[t]),
                .mul_done  (mul_done[t]),
                .ready_nd  (ready_nd[t])
            );
        end
    endgenerate

    bp_div_track #(
        .NT      (NT),
        .DIV_LAT (DIV_LAT),
        .EXT_DONE(EXT_DONE)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_vec(grant & is_div),
        .div_done (div_done),
        .div_free (div_free),
        .div_owner(div_owner)
    );

    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam int BASE = g * GROUP_SIZE;
            logic                  div_in;
            logic                  div_out;
            logic [GROUP_SIZE-1:0] req;
            logic [GROUP_SIZE-1:0] gnt;
            logic                  vld;
            logic [GIW-1:0]        idx;

            if (g == 0) begin : g_first
                assign div_in = 1'b0;
            end else begin : g_rest
                assign div_in = g_grp[g-1].div_out;
            end

            // Eligible threads: ready, not waiting on the divider, and a
            // divide only if the divider is free and not taken by an
            // earlier group this cycle.
            always_comb begin
                req = ready_nd[BASE +: GROUP_SIZE]
                    & ~div_owner[BASE +: GROUP_SIZE]
                    & (~is_div[BASE +: GROUP_SIZE]
                       | {GROUP_SIZE{div_free && !div_in}});
            end

            bp_group_arb #(.N(GROUP_SIZE)) u_arb (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (req),
                .gnt  (gnt),
                .valid(vld),
                .idx  (idx)
            );

            // Pass on whether the divider has been claimed this cycle.
            always_comb div_out = div_in || (|(gnt & is_div[BASE +: GROUP_SIZE]));

            assign grant[BASE +: GROUP_SIZE] = gnt;
            assign grp_valid[g]              = vld;
            assign grp_tid[g*TIDW +: TIDW]   = TIDW'(BASE) + TIDW'(idx);

            // R2: a group's valid flag tracks its grant bits.
            a_r2_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
                grp_valid[g] == (|grant[BASE +: GROUP_SIZE]));
        end
    endgenerate

    // R8: at most one divide granted across all groups in a cycle.
    a_r8_single_div_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant & is_div));

    // R7: the divider's owner is never granted.
    a_r7_owner_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & div_owner) == '0);

    // R2: grants only go to threads with a valid instruction.
    a_r2_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~inst_valid) == '0);

endmodule

// File: tb/barrel_picker_bench.sv
module barrel_picker_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] ALU = 2'd0, MUL = 2'd1, DIV = 2'd2, FPO = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  inst_valid = '0;
    logic [15:0] op_class = '0;
    logic [7:0]  fp_dep = '0;
    logic [7:0]  mul_done = '0;
    logic [7:0]  div_done = '0;
    logic [7:0]  grant;
    logic [1:0]  grp_valid;
    logic [5:0]  grp_tid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_picker u_barrel_picker (
        .clk       (clk),
        .rst_n     (rst_n),
        .inst_valid(inst_valid),
        .op_class  (op_class),
        .fp_dep    (fp_dep),
        .mul_done  (mul_done),
        .div_done  (div_done),
        .grant     (grant),
        .grp_valid (grp_valid),
        .grp_tid   (grp_tid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setop(input int t, input logic v, input logic [1:0] o, input logic d);
        inst_valid[t]     = v;
        op_class[2*t +: 2] = o;
        fp_dep[t]         = d;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    // Compare grant, group valid and thread IDs against an expected grant.
    task automatic expect_grant(input string req, input logic [7:0] g);
        #1;
        chk({req, " grant"}, int'(grant), int'(g));
        for (int k = 0; k < 2; k++) begin
            logic [3:0] sl;
            sl = g[4*k +: 4];
            chk({req, " grp_valid"}, int'(grp_valid[k]), int'(|sl));
            if (|sl) begin
                int id;
                id = 0;
                for (int b = 0; b < 4; b++) if (sl[b]) id = 4*k + b;
                chk({req, " grp_tid"}, int'(grp_tid[3*k +: 3]), id);
            end
        end
    endtask

    task automatic do_reset();
        inst_valid = '0; op_class = '0; fp_dep = '0;
        mul_done = '0; div_done = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1, R4: outputs idle after reset with nothing valid.
    task automatic test_reset();
        do_reset();
        expect_grant("R1 R4 reset idle", 8'h00);
    endtask

    // R1, R3, R11: all threads ready, both groups rotate in step.
    task automatic test_rotate();
        do_reset();
        for (int t = 0; t < 8; t++) setop(t, 1'b1, ALU, 1'b0);
        for (int c = 0; c < 6; c++) begin
            logic [7:0] e;
            e = 8'(1 << (c % 4)) | 8'(1 << (4 + c % 4));
            expect_grant("R1 R3 R11 rotation", e);
            next_cycle();
        end
    endtask

    // R3, R4: sparse requesters are skipped over; empty group idles.
    task automatic test_sparse();
        do_reset();
        setop(1, 1'b1, ALU, 1'b0);
        setop(3, 1'b1, ALU, 1'b0);
        expect_grant("R3 R4 sparse t1", 8'h02);
        next_cycle();
        expect_grant("R3 sparse t3", 8'h08);
        next_cycle();
        expect_grant("R3 sparse wrap t1", 8'h02);
    endtask

    // R5, R6: multiplies from two threads back to back, each blocks its thread.
    task automatic test_mul();
        do_reset();
        setop(0, 1'b1, MUL, 1'b0);
        setop(1, 1'b1, MUL, 1'b0);
        expect_grant("R5 R6 mul t0", 8'h01);
        next_cycle();
        expect_grant("R6 consecutive mul t1", 8'h02);
        next_cycle();
        setop(0, 1'b1, ALU, 1'b0);
        setop(1, 1'b1, ALU, 1'b0);
        for (int c = 2; c <= 5; c++) begin
            expect_grant("R6 mul blocked", 8'h00);
            next_cycle();
        end
        expect_grant("R6 t0 released", 8'h01);
        next_cycle();
        expect_grant("R6 t1 released", 8'h02);
    endtask

    // R7, R8, R10, R11: divide race, busy divider, ignored done pulses.
    task automatic test_div();
        do_reset();
        setop(0, 1'b1, DIV, 1'b0);
        setop(4, 1'b1, DIV, 1'b0);
        expect_grant("R8 group0 wins divide", 8'h01);
        next_cycle();
        setop(0, 1'b1, ALU, 1'b0);
        setop(5, 1'b1, ALU, 1'b0);
        for (int c = 1; c <= 24; c++) begin
            mul_done = (c == 3) ? 8'hFF : 8'h00;
            div_done = (c == 3) ? 8'hFF : 8'h00;
            expect_grant("R7 R10 R11 divider busy", 8'h20);
            next_cycle();
        end
        mul_done = '0; div_done = '0;
        expect_grant("R7 divider released", 8'h11);
    endtask

    // R9: dependent FP spacing; independent FP not delayed.
    task automatic test_fp();
        do_reset();
        setop(0, 1'b1, FPO, 1'b0);
        expect_grant("R9 first fp", 8'h01);
        next_cycle();
        setop(0, 1'b1, FPO, 1'b1);
        for (int c = 1; c <= 5; c++) begin
            expect_grant("R9 dependent fp waits", 8'h00);
            next_cycle();
        end
        expect_grant("R9 dependent fp at gap", 8'h01);
        next_cycle();
        setop(0, 1'b1, FPO, 1'b0);
        expect_grant("R9 independent fp no wait", 8'h01);
        next_cycle();
        setop(0, 1'b1, FPO, 1'b1);
        expect_grant("R9 window restarted", 8'h00);
    endtask

    initial begin
        test_reset();
        test_rotate();
        test_sparse();
        test_mul();
        test_div();
        test_fp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule